// File: doc/BRIEF.md
# Halting Real-Time Clock Register Bank

This block puts a bus-visible bank of time registers in front of a set of free-running BCD time counters (seconds, minutes, hours, day of week, date, month, year). Software reaches the bank through a simple synchronous port with a three-bit offset, write data, a write strobe and a read strobe. A once-per-second `tick` pulse from an external prescaler advances the counters. Offset 0 is the control register and offsets 1 to 7 are the time registers.

The visible registers are a separate copy of the counters. They normally follow the counters after each tick. Setting the control register's freeze-for-read flag or its set-time flag holds the visible copy so that software sees a coherent snapshot, and the counters keep running underneath. With the set-time flag raised, software writes a new time into the visible copy. Clearing the flag loads all seven time values into the counters in a single cycle. The control register also stores a five-bit calibration trim, which the block drives straight out to the prescaler.

Top module: `rtc_snapshot_bank`

## Requirements
- R1: After reset, reads return: offset 0 = 0x00, offset 1 = 0x80 (halt flag set, seconds 00), offsets 2 and 3 = 0x00, offsets 4, 5 and 6 = 0x01, offset 7 = 0x00. `cal_out` is 0.
- R2: While the halt flag (bit 7 written to offset 1) is 1, `tick` pulses do not change the counters. Writing offset 1 stores bit 7 as the halt flag and bits 6:0 as BCD seconds.
- R3: Each unhalted tick advances the BCD counters. Seconds and minutes wrap 59 to 00, hours wrap 23 to 00, day of week runs 1 to 7, date runs 1 to 31, month runs 1 to 12, and year wraps 99 to 00. Each wrap carries into the next field, and a carry out of hours advances both day of week and date.
- R4: While control bit 6 (freeze-for-read) is 1, the visible registers hold their values and the counters keep counting. After the bit is cleared, the first tick makes the visible copy show the full elapsed count.
- R5: While control bit 7 (set-time) is 1, ticks do not alter the visible registers, and software writes land in them. A control write that takes bit 7 from 1 to 0 copies offsets 1 to 7 into the counters in that cycle, and later ticks count from the loaded values.
- R6: When neither control bit 6 nor bit 7 is set, a write to a time register changes only the visible copy. The next tick overwrites it with the counter value.
- R7: All visible registers update in the single cycle after a counter step. A control write that sets a freeze bit in that same cycle does not block the update; the freeze applies from the next cycle.
- R8: Control bits 4:0 hold the calibration value, which drives `cal_out`. Reading offset 0 returns {bit 7 set-time, bit 6 freeze-for-read, bit 5 = 0, bits 4:0 calibration}.
- R9: `rd_data` shows the register at the offset sampled with `rd_en` one clock after the strobe. The offset map is 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| tick | input | 1 | One-second pulse from the prescaler |
| cal_out | output | 5 | Calibration trim to the prescaler |

## Verification
The hardest case to reach is a freeze request that arrives in exactly the cycle when the visible copy takes a counter step (R7). A bus transaction that is not aligned to the tick never lands there. The bench raises `tick` itself, drops it after one cycle, and issues the control write in the very next cycle. It then checks that the snapshot carries the new second and not the old one. Full carry chains (23:59:59 on day 7, date 31, month 12, year 99) are set up through a set-time load, so they need no long tick runs.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hr;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] dom;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] yr;
    } tk_time_t;

    localparam tk_time_t TIME_RESET = '{
        sec: 8'h00, min: 8'h00, hr: 8'h00,
        dow: 8'h01, dom: 8'h01, mon: 8'h01, yr: 8'h00
    };

    // Returns {carry, next}: wraps from top to base, else BCD increment.
    function automatic logic [BYTE_W:0] bcd_step(
        input logic [BYTE_W-1:0] v,
        input logic [BYTE_W-1:0] top,
        input logic [BYTE_W-1:0] base
    );
        logic [BYTE_W:0] r;
        if (v == top) begin
            r = {1'b1, base};
        end else if (v[3:0] == 4'h9) begin
            r = {1'b0, v[7:4] + 4'h1, 4'h0};
        end else begin
            r = {1'b0, v[7:4], v[3:0] + 4'h1};
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     halt,
    input  logic     load,
    input  tk_time_t load_val,
    output tk_time_t cnt,
    output logic     stepped
);

    typedef struct packed {
        tk_time_t cnt;
        logic     stepped;
    } core_st_t;

    core_st_t st_q, st_d;

    always_comb begin
        logic [BYTE_W:0] s;
        tk_time_t nx;
        nx = st_q.cnt;
        s = bcd_step(st_q.cnt.sec, 8'h59, 8'h00);
        nx.sec = s[BYTE_W-1:0];
        if (s[BYTE_W]) begin
            s = bcd_step(st_q.cnt.min, 8'h59, 8'h00);
            nx.min = s[BYTE_W-1:0];
            if (s[BYTE_W]) begin
                s = bcd_step(st_q.cnt.hr, 8'h23, 8'h00);
                nx.hr = s[BYTE_W-1:0];
                if (s[BYTE_W]) begin
                    s = bcd_step(st_q.cnt.dow, 8'h07, 8'h01);
                    nx.dow = s[BYTE_W-1:0];
                    s = bcd_step(st_q.cnt.dom, 8'h31, 8'h01);
                    nx.dom = s[BYTE_W-1:0];
                    if (s[BYTE_W]) begin
                        s = bcd_step(st_q.cnt.mon, 8'h12, 8'h01);
                        nx.mon = s[BYTE_W-1:0];
                        if (s[BYTE_W]) begin
                            s = bcd_step(st_q.cnt.yr, 8'h99, 8'h00);
                            nx.yr = s[BYTE_W-1:0];
                        end
                    end
                end
            end
        end

        st_d = st_q;
        st_d.stepped = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick && !halt) begin
            st_d.cnt     = nx;
            st_d.stepped = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt     <= TIME_RESET;
            st_q.stepped <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign stepped = st_q.stepped;

    assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load) |=> cnt == $past(cnt));

    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !halt && !load && cnt.sec == 8'h59) |=> cnt.sec == 8'h00);

endmodule

// File: rtl/rtc_visible_bank.sv
module rtc_visible_bank
    import rtc_bank_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CAL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  tk_time_t          cnt,
    input  logic              stepped,
    output tk_time_t          vis,
    output logic              halt,
    output logic              frz_rd,
    output logic              frz_wr,
    output logic [CAL_W-1:0]  cal,
    output logic              load
);

    localparam int BIT_WR = BYTE_W - 1;
    localparam int BIT_RD = BYTE_W - 2;

    typedef struct packed {
        tk_time_t         vis;
        logic             halt;
        logic             frz_rd;
        logic             frz_wr;
        logic [CAL_W-1:0] cal;
    } bank_st_t;

    bank_st_t b_q, b_d;
    logic frozen, ctrl_wr, time_wr;

    assign frozen  = b_q.frz_rd | b_q.frz_wr;
    assign ctrl_wr = wr_en && (addr == '0);
    assign time_wr = wr_en && (addr != '0);
    assign load    = ctrl_wr && b_q.frz_wr && !wr_data[BIT_WR];

    always_comb begin
        b_d = b_q;
        if (stepped && !frozen) begin
            b_d.vis = cnt;
        end
        if (ctrl_wr) begin
            b_d.frz_wr = wr_data[BIT_WR];
            b_d.frz_rd = wr_data[BIT_RD];
            b_d.cal    = wr_data[CAL_W-1:0];
        end
        if (time_wr) begin
            case (addr)
                3'd1: begin
                    b_d.vis.sec = {1'b0, wr_data[BYTE_W-2:0]};
                    b_d.halt    = wr_data[BIT_WR];
                end
                3'd2:    b_d.vis.min = wr_data;
                3'd3:    b_d.vis.hr  = wr_data;
                3'd4:    b_d.vis.dow = wr_data;
                3'd5:    b_d.vis.dom = wr_data;
                3'd6:    b_d.vis.mon = wr_data;
                default: b_d.vis.yr  = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q.vis    <= TIME_RESET;
            b_q.halt   <= 1'b1;
            b_q.frz_rd <= 1'b0;
            b_q.frz_wr <= 1'b0;
            b_q.cal    <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign vis    = b_q.vis;
    assign halt   = b_q.halt;
    assign frz_rd = b_q.frz_rd;
    assign frz_wr = b_q.frz_wr;
    assign cal    = b_q.cal;

    assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !time_wr) |=> vis == $past(vis));

    assert_follow_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stepped && !frozen && !time_wr) |=> vis == $past(cnt));

endmodule

// File: rtl/rtc_snapshot_bank.sv
module rtc_snapshot_bank
    import rtc_bank_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CAL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              tick,
    output logic [CAL_W-1:0]  cal_out
);

    localparam int PAD_W = BYTE_W - 2 - CAL_W;

    tk_time_t         cnt, vis;
    logic             stepped, halt, frz_rd, frz_wr, load;
    logic [CAL_W-1:0] cal;

    rtc_time_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .halt     (halt),
        .load     (load),
        .load_val (vis),
        .cnt      (cnt),
        .stepped  (stepped)
    );

    rtc_visible_bank #(.ADDR_W(ADDR_W), .CAL_W(CAL_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .cnt     (cnt),
        .stepped (stepped),
        .vis     (vis),
        .halt    (halt),
        .frz_rd  (frz_rd),
        .frz_wr  (frz_wr),
        .cal     (cal),
        .load    (load)
    );

    logic [BYTE_W-1:0] rd_q, rd_d;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            case (addr)
                3'd0:    rd_d = {frz_wr, frz_rd, {PAD_W{1'b0}}, cal};
                3'd1:    rd_d = {halt, vis.sec[BYTE_W-2:0]};
                3'd2:    rd_d = vis.min;
                3'd3:    rd_d = vis.hr;
                3'd4:    rd_d = vis.dow;
                3'd5:    rd_d = vis.dom;
                3'd6:    rd_d = vis.mon;
                default: rd_d = vis.yr;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;
    assign cal_out = cal;

    assert_ctrl_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == '0) |=> rd_data[CAL_W-1:0] == $past(cal_out));

    assert_read_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/sim_rtc_snapshot_bank.sv
module sim_rtc_snapshot_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic [4:0] cal_out;

    int checks = 0;
    int errors = 0;

    rtc_snapshot_bank u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .tick(tick), .cal_out(cal_out)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, exp);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] y);
        wr(3'd0, 8'h80);
        wr(3'd1, s); wr(3'd2, m); wr(3'd3, h);
        wr(3'd4, dw); wr(3'd5, dt); wr(3'd6, mo); wr(3'd7, y);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 3'd0, 8'h00);
        rd_chk("R1 sec", 3'd1, 8'h80);
        rd_chk("R1 min", 3'd2, 8'h00);
        rd_chk("R1 hour", 3'd3, 8'h00);
        rd_chk("R1 dow", 3'd4, 8'h01);
        rd_chk("R1 date", 3'd5, 8'h01);
        rd_chk("R1 month", 3'd6, 8'h01);
        rd_chk("R1 year", 3'd7, 8'h00);
        check("R1 cal_out", {3'b0, cal_out}, 8'h00);
    endtask

    task automatic t_halt;
        pulse(3);
        rd_chk("R2 halted seconds", 3'd1, 8'h80);
    endtask

    task automatic t_count_and_overwrite;
        wr(3'd1, 8'h00);
        pulse(3);
        rd_chk("R3 count 3", 3'd1, 8'h03);
        wr(3'd2, 8'h33);
        rd_chk("R6 visible min written", 3'd2, 8'h33);
        pulse(1);
        rd_chk("R6 min overwritten", 3'd2, 8'h00);
        rd_chk("R9 sec offset", 3'd1, 8'h04);
    endtask

    task automatic t_read_freeze;
        wr(3'd0, 8'h40);
        rd_chk("R8 ctrl read bit", 3'd0, 8'h40);
        pulse(2);
        rd_chk("R4 frozen sec", 3'd1, 8'h04);
        wr(3'd0, 8'h00);
        rd_chk("R4 held until tick", 3'd1, 8'h04);
        pulse(1);
        rd_chk("R4 caught up", 3'd1, 8'h07);
    endtask

    task automatic t_load_chain;
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        pulse(2);
        rd_chk("R5 frozen written sec", 3'd1, 8'h59);
        rd_chk("R5 frozen written year", 3'd7, 8'h99);
        wr(3'd0, 8'h00);
        pulse(1);
        rd_chk("R3 R5 sec wrap", 3'd1, 8'h00);
        rd_chk("R3 R5 min wrap", 3'd2, 8'h00);
        rd_chk("R3 R5 hour wrap", 3'd3, 8'h00);
        rd_chk("R3 R5 dow wrap", 3'd4, 8'h01);
        rd_chk("R3 R5 date wrap", 3'd5, 8'h01);
        rd_chk("R3 R5 month wrap", 3'd6, 8'h01);
        rd_chk("R3 R5 year wrap", 3'd7, 8'h00);
    endtask

    task automatic t_mid_carry;
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h15, 8'h06, 8'h24);
        wr(3'd0, 8'h00);
        pulse(1);
        rd_chk("R3 hour to 00", 3'd3, 8'h00);
        rd_chk("R3 dow 3 to 4", 3'd4, 8'h04);
        rd_chk("R3 date 15 to 16", 3'd5, 8'h16);
        rd_chk("R3 month kept", 3'd6, 8'h06);
        rd_chk("R3 year kept", 3'd7, 8'h24);
        set_time(8'h59, 8'h59, 8'h09, 8'h04, 8'h16, 8'h06, 8'h24);
        wr(3'd0, 8'h00);
        pulse(1);
        rd_chk("R3 hour 09 to 10", 3'd3, 8'h10);
        rd_chk("R3 min to 00", 3'd2, 8'h00);
        rd_chk("R3 date kept", 3'd5, 8'h16);
    endtask

    task automatic t_coincide;
        // seconds counter is 00 here
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        wr(3'd0, 8'h40);
        pulse(2);
        rd_chk("R7 update before freeze", 3'd1, 8'h01);
        wr(3'd0, 8'h00);
        pulse(1);
        rd_chk("R7 resumed", 3'd1, 8'h04);
    endtask

    task automatic t_cal;
        wr(3'd0, 8'h1D);
        check("R8 cal_out", {3'b0, cal_out}, 8'h1D);
        rd_chk("R8 ctrl cal", 3'd0, 8'h1D);
        wr(3'd0, 8'h3F);
        rd_chk("R8 bit5 reads 0", 3'd0, 8'h1F);
        check("R8 cal_out max", {3'b0, cal_out}, 8'h1F);
        wr(3'd0, 8'h00);
        check("R8 cal_out cleared", {3'b0, cal_out}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_halt();
        t_count_and_overwrite();
        t_read_freeze();
        t_load_chain();
        t_mid_carry();
        t_coincide();
        t_cal();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1ms;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule